// File: doc/BRIEF.md
# Sector-Restricted Connected-Block Enumerator

This block sits between the per-neuron receptive-field calculation and the weight addressing stage. For every incoming neuron it receives the inclusive window of connected coordinates on the x axis and on the y axis. The window is expressed in whole-layer coordinates and may reach past the layer edges. The block clips the window to the layer. It keeps only the coordinates that belong to the sector being simulated, and it converts those coordinates into block indices. It then walks the resulting rectangle of blocks in row-major order.

The layer is tiled by a power-of-two grid of sectors. A coordinate `c` belongs to the sector at in-block position `p` when `c mod SC == p`, and its block index is `c / SC`. Each output beat carries the linear block number of up to two neighbouring connected neurons from the same row, with a flag on the second lane and a marker on the last beat of the neuron. The sector number is constant for the whole sector, so only block numbers leave the block. A neuron whose window misses the sector produces no beat.

Top module: `conn_block_enum`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: On each axis the walk starts at block `ceil((max(first,0) - p) / SC)` and ends at block `floor((min(last, L-1) - p) / SC)`, where `L` is the layer size on that axis and `p` is the sector position; these are the blocks holding exactly the in-window coordinates with `c mod SC == p`.
- R3: Window coordinates below 0 or above `L-1` produce nothing and do not shift the emitted blocks.
- R4: `out_bn0` is the linear block number `bx + by * BCX`, where BCX is the number of blocks per row.
- R5: When `out_v1` is 1, `out_bn1` equals `out_bn0 + 1` and lies in the same block row.
- R6: A row with an odd number of connected blocks ends in a beat with `out_v1` = 0, and this is the only case where `out_v1` is 0.
- R7: Blocks are emitted in row-major order: x ascends within a row, then x returns to the first block and y steps up by one.
- R8: A neuron whose clipped window holds no coordinate of the current sector on either axis is accepted and produces no beat; `in_ready` is 1 again in the next cycle.
- R9: `out_last` is 1 on the final beat of a neuron only, and `out_valid` is 0 in the cycle after that beat is taken.
- R10: While `out_valid` is 1 and `out_ready` is 0, the beat on the outputs stays unchanged.
- R11: `in_ready` is 0 while a neuron is being walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window for one neuron is presented |
| in_ready | output | 1 | Block can accept a window |
| first_x | input | CW (signed) | Lowest connected x coordinate |
| last_x | input | CW (signed) | Highest connected x coordinate |
| first_y | input | CW (signed) | Lowest connected y coordinate |
| last_y | input | CW (signed) | Highest connected y coordinate |
| sec_x | input | SCX_LG | Sector position inside a block, x |
| sec_y | input | SCY_LG | Sector position inside a block, y |
| out_valid | output | 1 | A beat is presented |
| out_ready | input | 1 | Consumer takes the beat |
| out_bn0 | output | BCX_LG+BCY_LG | Linear block number, lane 0 |
| out_bn1 | output | BCX_LG+BCY_LG | Linear block number, lane 1 |
| out_v1 | output | 1 | Lane 1 carries a block |
| out_last | output | 1 | Final beat of the neuron |

## Verification
The assertions assume that `sec_x` and `sec_y` do not change while a neuron is being walked, and that window values fit the signed coordinate width. The stimulus changes the sector position only between neurons, after the previous walk has drained. Window ends are drawn from a range a little wider than the layer, so that clipping is exercised while values stay well inside the signed range. Inverted windows are allowed and count as empty. Backpressure comes from a random `out_ready`, which never depends on the outputs in the same cycle.

// File: rtl/cbe_pkg.sv
package cbe_pkg;
  typedef logic signed [15:0] coord_t;

  function automatic coord_t clamp_lo(coord_t v);
    return (v < 0) ? coord_t'(0) : v;
  endfunction

  function automatic coord_t clamp_hi(coord_t v, coord_t top);
    return (v > top) ? top : v;
  endfunction

  // smallest block whose sector coordinate is >= v
  function automatic coord_t ceil_blk(coord_t v, coord_t pos, int lg);
    coord_t t;
    t = v - pos + ((coord_t'(1) <<< lg) - coord_t'(1));
    return t >>> lg;
  endfunction

  // largest block whose sector coordinate is <= v (may be -1)
  function automatic coord_t floor_blk(coord_t v, coord_t pos, int lg);
    coord_t t;
    t = v - pos;
    return t >>> lg;
  endfunction

  function automatic logic [15:0] lin_bn(logic [15:0] bx, logic [15:0] by, int bcx_lg);
    return bx + (by << bcx_lg);
  endfunction
endpackage

// File: rtl/cbe_axis_match.sv
module cbe_axis_match
  import cbe_pkg::*;
#(
  parameter int SC_LG = 2,
  parameter int BC_LG = 3,
  parameter int CW    = 8
) (
  input  logic signed [CW-1:0] lo,
  input  logic signed [CW-1:0] hi,
  input  logic [SC_LG-1:0]     pos,
  output logic [BC_LG-1:0]     blk_lo,
  output logic [BC_LG-1:0]     blk_hi,
  output logic                 hit
);
  localparam int L_LG = SC_LG + BC_LG;
  localparam coord_t TOP = coord_t'((1 << L_LG) - 1);
  localparam coord_t BMAX = coord_t'((1 << BC_LG) - 1);

  coord_t lo_c, hi_c, p_c, b_lo, b_hi;
  logic   in_layer;

  always_comb begin
    p_c  = coord_t'({1'b0, pos});
    lo_c = clamp_lo(coord_t'(lo));
    hi_c = clamp_hi(coord_t'(hi), TOP);
    b_lo = ceil_blk(lo_c, p_c, SC_LG);
    b_hi = floor_blk(hi_c, p_c, SC_LG);
    in_layer = (lo_c <= hi_c);
    hit = in_layer && (b_lo <= b_hi);
    blk_lo = b_lo[BC_LG-1:0];
    blk_hi = b_hi[BC_LG-1:0];
  end

  // R2 / R3: a hit never points outside the layer's block grid
  always_comb begin
    if (hit) begin
      a_r3_blk_in_grid: assert (b_lo >= 0 && b_hi <= BMAX);
    end
  end
endmodule

// File: rtl/cbe_block_walker.sv
module cbe_block_walker #(
  parameter int BCX_LG = 3,
  parameter int BCY_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BCX_LG-1:0] bx_lo,
  input  logic [BCX_LG-1:0] bx_hi,
  input  logic [BCY_LG-1:0] by_lo,
  input  logic [BCY_LG-1:0] by_hi,
  input  logic              take,
  output logic              busy,
  output logic [BCX_LG-1:0] cx,
  output logic [BCY_LG-1:0] cy,
  output logic              lane1_ok,
  output logic              row_end,
  output logic              final_beat
);
  logic [BCX_LG-1:0] xlo_q, xhi_q;
  logic [BCY_LG-1:0] yhi_q;
  logic [BCX_LG:0]   cx_nx;
  logic              fire;

  assign cx_nx      = {1'b0, cx} + {{BCX_LG{1'b0}}, 1'b1};
  assign lane1_ok   = (cx_nx <= {1'b0, xhi_q});
  assign row_end    = (cx_nx >= {1'b0, xhi_q});
  assign final_beat = row_end && (cy == yhi_q);
  assign fire       = busy && take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cx    <= '0;
      cy    <= '0;
      xlo_q <= '0;
      xhi_q <= '0;
      yhi_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cx    <= bx_lo;
      cy    <= by_lo;
      xlo_q <= bx_lo;
      xhi_q <= bx_hi;
      yhi_q <= by_hi;
    end else if (fire) begin
      if (final_beat) begin
        busy <= 1'b0;
      end else if (row_end) begin
        cx <= xlo_q;
        cy <= cy + {{(BCY_LG-1){1'b0}}, 1'b1};
      end else begin
        cx <= cx + {{(BCX_LG-1){1'b0}}, 2'd2};
      end
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take) |=> (busy && $stable(cx) && $stable(cy)));

  a_r7_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && row_end && !final_beat) |=> (cx == xlo_q && cy == $past(cy) + 1'b1));

  a_r7_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !row_end) |=> (cy == $past(cy) && cx == $past(cx) + 2'd2));

  a_r6_odd_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lane1_ok) |-> row_end);
endmodule

// File: rtl/conn_block_enum.sv
module conn_block_enum
  import cbe_pkg::*;
#(
  parameter int SCX_LG = 2,
  parameter int SCY_LG = 2,
  parameter int BCX_LG = 3,
  parameter int BCY_LG = 3,
  parameter int CW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic signed [CW-1:0]      first_x,
  input  logic signed [CW-1:0]      last_x,
  input  logic signed [CW-1:0]      first_y,
  input  logic signed [CW-1:0]      last_y,
  input  logic [SCX_LG-1:0]         sec_x,
  input  logic [SCY_LG-1:0]         sec_y,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [BCX_LG+BCY_LG-1:0]  out_bn0,
  output logic [BCX_LG+BCY_LG-1:0]  out_bn1,
  output logic                      out_v1,
  output logic                      out_last
);
  localparam int BN_W = BCX_LG + BCY_LG;

  logic [BCX_LG-1:0] bx_lo, bx_hi, cx;
  logic [BCY_LG-1:0] by_lo, by_hi, cy;
  logic hit_x, hit_y, accept, start, busy;
  logic lane1_ok, row_end, final_beat;

  cbe_axis_match #(.SC_LG(SCX_LG), .BC_LG(BCX_LG), .CW(CW)) u_ax (
    .lo(first_x), .hi(last_x), .pos(sec_x),
    .blk_lo(bx_lo), .blk_hi(bx_hi), .hit(hit_x)
  );

  cbe_axis_match #(.SC_LG(SCY_LG), .BC_LG(BCY_LG), .CW(CW)) u_ay (
    .lo(first_y), .hi(last_y), .pos(sec_y),
    .blk_lo(by_lo), .blk_hi(by_hi), .hit(hit_y)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign start    = accept && hit_x && hit_y;

  cbe_block_walker #(.BCX_LG(BCX_LG), .BCY_LG(BCY_LG)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bx_lo(bx_lo), .bx_hi(bx_hi), .by_lo(by_lo), .by_hi(by_hi),
    .take(out_ready), .busy(busy), .cx(cx), .cy(cy),
    .lane1_ok(lane1_ok), .row_end(row_end), .final_beat(final_beat)
  );

  assign out_valid = busy;
  assign out_v1    = lane1_ok;
  assign out_last  = final_beat;
  assign out_bn0   = BN_W'(lin_bn(16'(cx), 16'(cy), BCX_LG));
  assign out_bn1   = lane1_ok ? BN_W'(lin_bn(16'(cx) + 16'd1, 16'(cy), BCX_LG)) : '0;

  a_r11_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r8_empty_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(hit_x && hit_y)) |=> (!out_valid && in_ready));

  a_r9_last_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  a_r5_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_v1) |-> (out_bn1 == out_bn0 + 1'b1));

  a_r10_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bn0) && $stable(out_last) && $stable(out_v1)));
endmodule

// File: tb/sim_conn_block_enum.sv
`timescale 1ns/1ps
module sim_conn_block_enum;
  localparam int SCX_LG = 2, SCY_LG = 2, BCX_LG = 3, BCY_LG = 3, CW = 8;
  localparam int LX = 1 << (SCX_LG + BCX_LG);
  localparam int LY = 1 << (SCY_LG + BCY_LG);
  localparam int BCX = 1 << BCX_LG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_v1, out_last;
  logic signed [CW-1:0] first_x = '0, last_x = '0, first_y = '0, last_y = '0;
  logic [SCX_LG-1:0] sec_x = '0;
  logic [SCY_LG-1:0] sec_y = '0;
  logic [BCX_LG+BCY_LG-1:0] out_bn0, out_bn1;

  int n_chk = 0, n_bad = 0;
  int e_bn0 [64];
  int e_v1  [64];
  int e_last[64];
  int n_exp;

  always #4 clk = ~clk;

  conn_block_enum #(.SCX_LG(SCX_LG), .SCY_LG(SCY_LG), .BCX_LG(BCX_LG),
                    .BCY_LG(BCY_LG), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .first_x(first_x), .last_x(last_x), .first_y(first_y), .last_y(last_y),
    .sec_x(sec_x), .sec_y(sec_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_bn0(out_bn0), .out_bn1(out_bn1), .out_v1(out_v1), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // brute force: scan every coordinate of the layer on one axis
  task automatic axis_blocks(input int f, input int l, input int pos, input int sc,
                             input int len, output int b0, output int cnt);
    b0 = 0; cnt = 0;
    for (int c = 0; c < len; c++) begin
      if (c >= f && c <= l && (c % sc) == pos) begin
        if (cnt == 0) b0 = c / sc;
        cnt++;
      end
    end
  endtask

  task automatic build_exp(input int fx, input int lx, input int fy, input int ly,
                           input int px, input int py);
    int x0, nx, y0, ny;
    axis_blocks(fx, lx, px, 1 << SCX_LG, LX, x0, nx);
    axis_blocks(fy, ly, py, 1 << SCY_LG, LY, y0, ny);
    n_exp = 0;
    if (nx == 0 || ny == 0) return;
    for (int r = 0; r < ny; r++) begin
      for (int k = 0; k < nx; k += 2) begin
        e_bn0[n_exp]  = (x0 + k) + (y0 + r) * BCX;
        e_v1[n_exp]   = (k + 1 < nx) ? 1 : 0;
        e_last[n_exp] = 0;
        n_exp++;
      end
    end
    e_last[n_exp-1] = 1;
  endtask

  task automatic run_neuron(input int fx, input int lx, input int fy, input int ly,
                            input int px, input int py, input int stall, input string tag);
    int idx, guard;
    bit held;
    int h_bn0, h_v1, h_last;
    build_exp(fx, lx, fy, ly, px, py);
    @(negedge clk);
    first_x = CW'(fx); last_x = CW'(lx); first_y = CW'(fy); last_y = CW'(ly);
    sec_x = SCX_LG'(px); sec_y = SCY_LG'(py);
    in_valid = 1'b1;
    chk(in_ready == 1'b1, "R11 idle in_ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    if (n_exp == 0) begin
      chk(out_valid == 1'b0, {tag, " R8 no beat"}, int'(out_valid), 0);
      chk(in_ready == 1'b1, {tag, " R8 ready again"}, int'(in_ready), 1);
      return;
    end
    chk(in_ready == 1'b0, "R11 busy in_ready", int'(in_ready), 0);
    idx = 0; guard = 0; held = 0;
    h_bn0 = 0; h_v1 = 0; h_last = 0;
    while (idx < n_exp && guard < 400) begin
      guard++;
      if (!out_valid) begin
        chk(1'b0, {tag, " R7 beat count"}, idx, n_exp);
        break;
      end
      if (held) begin
        chk(int'(out_bn0) == h_bn0, "R10 held bn0", int'(out_bn0), h_bn0);
        chk(int'(out_v1) == h_v1 && int'(out_last) == h_last, "R10 held flags",
            int'(out_v1) * 2 + int'(out_last), h_v1 * 2 + h_last);
      end
      out_ready = (stall != 0) ? (($urandom % 3) != 0) : 1'b1;
      if (out_ready) begin
        chk(int'(out_bn0) == e_bn0[idx], {tag, " R4 R7 bn0"}, int'(out_bn0), e_bn0[idx]);
        chk(int'(out_v1) == e_v1[idx], {tag, " R6 lane1 valid"}, int'(out_v1), e_v1[idx]);
        if (e_v1[idx] != 0)
          chk(int'(out_bn1) == e_bn0[idx] + 1, {tag, " R5 bn1"}, int'(out_bn1), e_bn0[idx] + 1);
        chk(int'(out_last) == e_last[idx], {tag, " R9 last"}, int'(out_last), e_last[idx]);
        idx++;
        held = 0;
      end else begin
        held = 1;
        h_bn0 = int'(out_bn0); h_v1 = int'(out_v1); h_last = int'(out_last);
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, {tag, " R9 drained"}, int'(out_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    // whole layer and beyond, clipped
    run_neuron(-20, 60, -9, 45, 3, 1, 0, "R3 full");
    // window starting mid-block: ceil on first, floor on last
    run_neuron(5, 18, 6, 14, 1, 2, 0, "R2 mid");
    // single block
    run_neuron(9, 9, 22, 22, 1, 2, 0, "R2 single");
    // odd row of three blocks
    run_neuron(0, 11, 0, 3, 0, 0, 0, "R6 odd");
    // window entirely left of layer
    run_neuron(-12, -1, 0, 31, 0, 0, 0, "R3 left");
    // window entirely past the top edge
    run_neuron(0, 31, 32, 50, 0, 0, 0, "R3 top");
    // window inside one block missing this sector
    run_neuron(4, 6, 4, 6, 3, 0, 0, "R8 miss");
    // inverted window
    run_neuron(12, 8, 3, 9, 0, 1, 0, "R8 inverted");
    // backpressure on a large walk
    run_neuron(-3, 40, 2, 29, 2, 3, 1, "R10 stall");
    for (int i = 0; i < 250; i++) begin
      int fx, fy, wx, wy;
      fx = int'($urandom % 48) - 8;
      fy = int'($urandom % 48) - 8;
      wx = int'($urandom % 24) - 2;
      wy = int'($urandom % 24) - 2;
      run_neuron(fx, fx + wx, fy, fy + wy, int'($urandom % 4), int'($urandom % 4),
                 int'($urandom % 2), "R2 R7 rand");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule